// File: doc/BRIEF.md
# Load-Adaptive Valley Number Counter

This block holds the valley number that the switch-on logic of a quasi-resonant flyback controller waits for before it turns the power switch on again. It ranges from 1 to 7. A high valley number stretches the off-time, so the switching frequency falls as the load drops. Feedback comparator flags are gathered over one evaluation period, which is 48 ms in the target system. On each evaluation tick the gathered flags decide one of three actions: step the valley number up, hold it, or step it down.

Two sets of feedback comparator flags arrive, one set for each mains range. A line-range latch picks which set applies. The latch moves to high line when the zero-crossing pin current passes the upper current flag, which is 1.3 mA in the target system. It returns to low line when that current falls below the lower flag, which is 0.8 mA. The gap between the two flags stops the selection from chattering.

Three events force the valley number straight back to 1:
- a feedback level above the reset threshold;
- the start-up pulse;
- an external set-to-one strobe, raised when burst mode is left.

The evaluation tick comes from one of two places, chosen by a parameter. It is either taken from an input or produced by an internal cycle divider.

Top module: `valley_count`

## Requirements
- R1: After `rst_n` is released, `valley_num` is 1. It never leaves the range 1 to 7.
- R2: `valley_num` changes only in the cycle after a tick, a reset-threshold flag, a start-up pulse or a set-to-one strobe.
- R3: On a tick where the selected low-threshold flag was never high in the period, `valley_num` rises by 1. It saturates at 7.
- R4: On a tick where the selected low-threshold flag was high at least once in the period, but the selected high-threshold flag never was, `valley_num` is unchanged.
- R5: On a tick where the selected high-threshold flag was high at least once in the period, `valley_num` falls by 1. It saturates at 1.
- R6: When `fb_over_reset` is high in any cycle, `valley_num` is 1 in the next cycle. This also applies when a tick falls in the same cycle.
- R7: When `startup_pulse` or `force_one` is high, `valley_num` is 1 in the next cycle, whatever the tick does. A start-up pulse also discards the flags gathered so far in the period.
- R8: Line selection starts at low line, where the `*_low_line` flags apply. When `izc_over_upper` is high, high line applies from the next cycle on, and the `*_high_line` flags are used. When `izc_under_lower` alone is high, low line applies from the next cycle. When neither is high, the selection is kept. When both are high, high line is chosen.
- R9: A flag counts for the period if it is high in any cycle of that period, including the tick cycle itself. The gathered flags are cleared after each tick.
- R10: With `TICK_DIV` = N > 0, a tick occurs every N cycles, counted from reset release, and `eval_tick` has no effect. With `TICK_DIV` = 0, `eval_tick` is the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_tick | input | 1 | Evaluation tick; used when TICK_DIV is 0 |
| fb_lo_low_line | input | 1 | Feedback above the low threshold, low-line set |
| fb_hi_low_line | input | 1 | Feedback above the high threshold, low-line set |
| fb_lo_high_line | input | 1 | Feedback above the low threshold, high-line set |
| fb_hi_high_line | input | 1 | Feedback above the high threshold, high-line set |
| fb_over_reset | input | 1 | Feedback above the reset threshold |
| izc_over_upper | input | 1 | Zero-crossing current above the upper line flag |
| izc_under_lower | input | 1 | Zero-crossing current below the lower line flag |
| startup_pulse | input | 1 | Start-up event |
| force_one | input | 1 | External set-to-one strobe |
| valley_num | output | CNT_W | Requested valley number, 1 to 7 |

## Verification
Several functions of this block can fall in the same cycle. The most important pair is a periodic evaluation tick arriving together with a forcing event, either the reset-threshold flag or the set-to-one strobe. The bench provokes this on purpose, with a tick that would otherwise count up. It requires `valley_num` to be 1 in the next cycle. A second collision is a threshold flag that rises only in the tick cycle itself, which must still decide that tick. A third is both line-current flags high at once, where high line must be chosen. Random cycles mix all of these against a bench model derived from the requirements.

// File: rtl/valley_pkg.sv
package valley_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   // Three-way decision from the flags gathered over one period.
   function automatic step_e pick_step(input logic crossed_lo, input logic crossed_hi);
      if (!crossed_lo)
         return STEP_UP;
      else if (!crossed_hi)
         return STEP_HOLD;
      else
         return STEP_DOWN;
   endfunction

endpackage

// File: rtl/valley_tick_gen.sv
module valley_tick_gen #(
   parameter int DIV = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic tick_o
);
   generate
      if (DIV == 0) begin : g_ext
         assign tick_o = tick_i;
      end else begin : g_div
         localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);
         logic [DW-1:0] div_q;
         logic          unused_tick;

         assign unused_tick = tick_i;
         assign tick_o      = (div_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n)
               div_q <= '0;
            else if (div_q == LAST)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end

         if (DIV > 1) begin : g_chk
            AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
               tick_o |=> !tick_o); // R10
         end
      end
   endgenerate
endmodule

// File: rtl/valley_line_sel.sv
module valley_line_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic izc_up,
   input  logic izc_dn,
   input  logic lo_ll,
   input  logic hi_ll,
   input  logic lo_hl,
   input  logic hi_hl,
   output logic lo_sel,
   output logic hi_sel
);
   logic high_line_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         high_line_q <= 1'b0;
      else if (izc_up)
         high_line_q <= 1'b1;
      else if (izc_dn)
         high_line_q <= 1'b0;
   end

   assign lo_sel = high_line_q ? lo_hl : lo_ll;
   assign hi_sel = high_line_q ? hi_hl : hi_ll;

   AST_LINE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!izc_up && !izc_dn) |=> $stable(high_line_q)); // R8
   AST_LINE_UP: assert property (@(posedge clk) disable iff (!rst_n)
      izc_up |=> high_line_q); // R8
endmodule

// File: rtl/valley_flag_hold.sv
module valley_flag_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lo_in,
   input  logic hi_in,
   output logic seen_lo,
   output logic seen_hi
);
   logic lo_q, hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         lo_q <= 1'b0;
         hi_q <= 1'b0;
      end else begin
         lo_q <= lo_q | lo_in;
         hi_q <= hi_q | hi_in;
      end
   end

   // The flag of the current cycle (the tick cycle itself) also counts.
   assign seen_lo = lo_q | lo_in;
   assign seen_hi = hi_q | hi_in;

   AST_STICKY_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && lo_q) |=> lo_q); // R9
   AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!lo_q && !hi_q)); // R9
endmodule

// File: rtl/valley_count_core.sv
module valley_count_core
   import valley_pkg::*;
#(
   parameter int W    = 3,
   parameter int MINV = 1,
   parameter int MAXV = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         force_min,
   input  logic         tick,
   input  logic         seen_lo,
   input  logic         seen_hi,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] MIN_C = W'(MINV);
   localparam logic [W-1:0] MAX_C = W'(MAXV);

   logic [W-1:0] cnt_q;
   step_e        act;

   assign act = pick_step(seen_lo, seen_hi);

   always_ff @(posedge clk) begin
      if (!rst_n || force_min)
         cnt_q <= MIN_C;
      else if (tick) begin
         unique case (act)
            STEP_UP:   if (cnt_q < MAX_C) cnt_q <= cnt_q + 1'b1;
            STEP_DOWN: if (cnt_q > MIN_C) cnt_q <= cnt_q - 1'b1;
            default:   cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt_o = cnt_q;

   AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= MIN_C) && (cnt_q <= MAX_C)); // R1
   AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_min && !tick) |=> $stable(cnt_q)); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !force_min && !seen_lo && cnt_q == MAX_C) |=> cnt_q == MAX_C); // R3
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !force_min && seen_lo && !seen_hi) |=> $stable(cnt_q)); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !force_min && seen_lo && seen_hi && cnt_q == MIN_C) |=> cnt_q == MIN_C); // R5
   AST_FORCE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      force_min |=> cnt_q == MIN_C); // R6
endmodule

// File: rtl/valley_count.sv
module valley_count #(
   parameter int CNT_W    = 3,
   parameter int MIN_VAL  = 1,
   parameter int MAX_VAL  = 7,
   parameter int TICK_DIV = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval_tick,
   input  logic             fb_lo_low_line,
   input  logic             fb_hi_low_line,
   input  logic             fb_lo_high_line,
   input  logic             fb_hi_high_line,
   input  logic             fb_over_reset,
   input  logic             izc_over_upper,
   input  logic             izc_under_lower,
   input  logic             startup_pulse,
   input  logic             force_one,
   output logic [CNT_W-1:0] valley_num
);
   generate
      if (MIN_VAL < 1 || MIN_VAL > MAX_VAL) begin : g_bad_range
         $error("valley_count: MIN_VAL must be 1..MAX_VAL");
      end
      if (MAX_VAL >= (1 << CNT_W)) begin : g_bad_width
         $error("valley_count: CNT_W too narrow for MAX_VAL");
      end
      if (TICK_DIV < 0) begin : g_bad_div
         $error("valley_count: TICK_DIV must not be negative");
      end
   endgenerate

   logic tick, lo_sel, hi_sel, seen_lo, seen_hi, force_min, clr_flags;

   assign force_min = fb_over_reset | startup_pulse | force_one;
   assign clr_flags = tick | startup_pulse;

   valley_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_i(eval_tick), .tick_o(tick));

   valley_line_sel u_line (
      .clk(clk), .rst_n(rst_n),
      .izc_up(izc_over_upper), .izc_dn(izc_under_lower),
      .lo_ll(fb_lo_low_line), .hi_ll(fb_hi_low_line),
      .lo_hl(fb_lo_high_line), .hi_hl(fb_hi_high_line),
      .lo_sel(lo_sel), .hi_sel(hi_sel));

   valley_flag_hold u_flags (
      .clk(clk), .rst_n(rst_n), .clr(clr_flags),
      .lo_in(lo_sel), .hi_in(hi_sel),
      .seen_lo(seen_lo), .seen_hi(seen_hi));

   valley_count_core #(.W(CNT_W), .MINV(MIN_VAL), .MAXV(MAX_VAL)) u_core (
      .clk(clk), .rst_n(rst_n), .force_min(force_min), .tick(tick),
      .seen_lo(seen_lo), .seen_hi(seen_hi), .cnt_o(valley_num));

   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (startup_pulse || force_one) |=> valley_num == CNT_W'(MIN_VAL)); // R7
   AST_RESET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      fb_over_reset |=> valley_num == CNT_W'(MIN_VAL)); // R6
endmodule

// File: tb/valley_count_test.sv
module valley_count_test;
   localparam int NDIV = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tk, lo_ll, hi_ll, lo_hl, hi_hl, rf, izh, izl, st, s1;
   logic [2:0] valley, valley_div;

   int total = 0;
   int bad   = 0;

   int m_cnt;
   logic m_line, m_slo, m_shi;

   always #2 clk = ~clk;

   valley_count uut (
      .clk(clk), .rst_n(rst_n), .eval_tick(tk),
      .fb_lo_low_line(lo_ll), .fb_hi_low_line(hi_ll),
      .fb_lo_high_line(lo_hl), .fb_hi_high_line(hi_hl),
      .fb_over_reset(rf), .izc_over_upper(izh), .izc_under_lower(izl),
      .startup_pulse(st), .force_one(s1), .valley_num(valley));

   valley_count #(.TICK_DIV(NDIV)) uut_div (
      .clk(clk), .rst_n(rst_n), .eval_tick(1'b1),
      .fb_lo_low_line(1'b0), .fb_hi_low_line(1'b0),
      .fb_lo_high_line(1'b0), .fb_hi_high_line(1'b0),
      .fb_over_reset(1'b0), .izc_over_upper(1'b0), .izc_under_lower(1'b0),
      .startup_pulse(1'b0), .force_one(1'b0), .valley_num(valley_div));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference step derived from the requirements; returns the tag exercised.
   function automatic string model_step();
      logic lo, hi;
      string tag;
      lo = m_line ? lo_hl : lo_ll;
      hi = m_line ? hi_hl : hi_ll;
      tag = "R2";
      if (st || s1) begin
         m_cnt = 1; tag = "R7";
      end else if (rf) begin
         m_cnt = 1; tag = "R6";
      end else if (tk) begin
         if (!(m_slo | lo)) begin
            if (m_cnt < 7) m_cnt++;
            tag = "R3";
         end else if (!(m_shi | hi)) begin
            tag = "R4";
         end else begin
            if (m_cnt > 1) m_cnt--;
            tag = "R5";
         end
      end
      if (tk || st) begin
         m_slo = 1'b0; m_shi = 1'b0;
      end else begin
         m_slo = m_slo | lo; m_shi = m_shi | hi;
      end
      if (izh) m_line = 1'b1;
      else if (izl) m_line = 1'b0;
      return tag;
   endfunction

   task automatic drive(input logic t, input logic a, input logic b, input logic c,
                        input logic d, input logic r, input logic ih, input logic il,
                        input logic s, input logic o);
      string tag;
      tk = t; lo_ll = a; hi_ll = b; lo_hl = c; hi_hl = d;
      rf = r; izh = ih; izl = il; st = s; s1 = o;
      tag = model_step();
      @(posedge clk);
      @(negedge clk);
      chk(tag, int'(valley), m_cnt);
   endtask

   task automatic idle();
      drive(0,0,0,0,0,0,0,0,0,0);
   endtask

   task automatic up_tick();
      drive(1,0,0,0,0,0,0,0,0,0);
   endtask

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      tk = 0; lo_ll = 0; hi_ll = 0; lo_hl = 0; hi_hl = 0;
      rf = 0; izh = 0; izl = 0; st = 0; s1 = 0;
      m_cnt = 1; m_line = 1'b0; m_slo = 1'b0; m_shi = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset value", int'(valley), 1);

      // Idle: count holds; divided instance ticks every NDIV cycles, input tick ignored
      repeat (3 * NDIV) idle();
      chk("R2 idle hold", int'(valley), 1);
      chk("R10 divided tick", int'(valley_div), 4);
      repeat (NDIV) idle();
      chk("R10 divided tick", int'(valley_div), 5);

      // Count up with saturation
      repeat (8) begin up_tick(); idle(); end
      chk("R3 saturate at 7", int'(valley), 7);

      // Low crossing earlier in period -> hold
      drive(0,1,0,0,0,0,0,0,0,0); idle(); up_tick();
      chk("R4 hold / R9 sticky", int'(valley), 7);

      // Crossings only in the tick cycle -> step down
      drive(1,1,1,0,0,0,0,0,0,0);
      chk("R5 / R9 tick-cycle flag", int'(valley), 6);
      repeat (7) drive(1,1,1,0,0,0,0,0,0,0);
      chk("R5 saturate at 1", int'(valley), 1);

      // Reset-threshold flag
      repeat (3) up_tick();
      chk("R3 count up", int'(valley), 4);
      drive(0,0,0,0,0,1,0,0,0,0);
      chk("R6 reset flag", int'(valley), 1);
      repeat (2) up_tick();
      drive(1,0,0,0,0,1,0,0,0,0);
      chk("R6 with tick", int'(valley), 1);

      // Set-to-one strobe and start-up pulse against a rising tick
      repeat (2) up_tick();
      drive(1,0,0,0,0,0,0,0,0,1);
      chk("R7 strobe with tick", int'(valley), 1);
      repeat (2) up_tick();
      drive(0,0,0,0,0,0,0,0,1,0);
      chk("R7 startup", int'(valley), 1);
      drive(0,1,0,0,0,0,0,0,0,0);
      drive(0,0,0,0,0,0,0,0,1,0);
      up_tick();
      chk("R7 startup clears flags", int'(valley), 2);

      // Line selection hysteresis
      drive(0,0,0,0,0,0,1,0,0,0);
      drive(0,1,0,0,0,0,0,0,0,0); up_tick();
      chk("R8 high line ignores low-line flag", int'(valley), 3);
      drive(0,0,0,1,0,0,0,0,0,0); up_tick();
      chk("R8 high line uses its flag", int'(valley), 3);
      drive(0,0,0,0,0,0,1,1,0,0);
      drive(0,1,0,0,0,0,0,0,0,0); up_tick();
      chk("R8 both current flags -> high", int'(valley), 4);
      drive(0,0,0,0,0,0,0,1,0,0);
      drive(0,1,0,0,0,0,0,0,0,0); up_tick();
      chk("R8 back to low line", int'(valley), 4);

      // Constrained random mix
      for (int i = 0; i < 3000; i++) begin
         drive(($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 14) == 0,
               ($urandom % 6) == 0, ($urandom % 14) == 0, ($urandom % 50) == 0,
               ($urandom % 25) == 0, ($urandom % 25) == 0,
               ($urandom % 90) == 0, ($urandom % 70) == 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule